// File: doc/BRIEF.md
# Ingress Lane Sync and Deskew Qualifier

This block supervises the synchronization state of a SPI-4-style ingress data path. Upstream logic computes a DIP-4 parity result once per checked word and presents it as a one-cycle pulse with an error flag. The deskew aligner reports each alignment attempt as a one-cycle pulse with an in-range flag. A divided copy of the ingress data clock also arrives, asynchronous to the system clock. The block turns these inputs into three registered status flags: sync, deskew out of range, and clock available.

The sync flag has hysteresis. It rises only after a programmable number of good parity checks in a row. It falls only after a separate programmable number of parity errors in a row. The deskew flag follows either every single result or only results that two consecutive attempts agree on. A configuration bit chooses between the two. Clock presence is judged by a watchdog in the system clock domain. The watchdog reloads on every toggle of the synchronized divided clock. Losing the clock, or clearing the enable bit, drops the path out of sync and discards any partly counted run. Software holds the enable bit low through reset and while it configures the port, which keeps the path idle.

Top module: `ingress_sync_qualifier`

## Requirements
- R1: After reset, sync_ok, dsk_oor and clk_avail are all 0.
- R2: While enable is 0, sync_ok and dsk_oor are 0 one cycle later, and parity and deskew pulses are ignored. Both run counters are cleared, so a run starts from zero after enable returns to 1.
- R3: sync_ok rises in the cycle after the good check that brings the count of consecutive good checks (dip_valid=1, dip_err=0) up to insync_thr. A value of 0 acts as 1. Cycles with dip_valid=0 neither add to a run nor break it.
- R4: A parity error (dip_valid=1, dip_err=1) restarts the good run from zero.
- R5: While in sync, sync_ok falls in the cycle after the error that brings the count of consecutive errors up to outsync_thr. A good check restarts the error run from zero.
- R6: With dsk_confirm=0, each deskew pulse sets dsk_oor to the inverse of dsk_in_range one cycle later.
- R7: With dsk_confirm=1, dsk_oor takes the value NOT dsk_in_range only when the pulse carries the same dsk_in_range as the previous deskew pulse. A pulse that differs from the previous one leaves dsk_oor unchanged.
- R8: clk_avail becomes 1 within SYNC_STAGES+2 cycles of a toggle of ing_clk_div. It returns to 0 once no toggle has been seen for WDOG_CYCLES cycles.
- R9: When clk_avail is 0, sync_ok is forced to 0 and both run counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Ingress path enable; 0 holds the path disabled |
| dsk_confirm | input | 1 | 1 requires two matching deskew results before one is accepted |
| insync_thr | input | 4 | Number of consecutive good checks needed to enter sync |
| outsync_thr | input | 4 | Number of consecutive errors needed to leave sync |
| dip_valid | input | 1 | One-cycle pulse: a parity check result is present |
| dip_err | input | 1 | Parity check failed, qualified by dip_valid |
| dsk_valid | input | 1 | One-cycle pulse: a deskew attempt result is present |
| dsk_in_range | input | 1 | Deskew result lies within range, qualified by dsk_valid |
| ing_clk_div | input | 1 | Divided ingress data clock, asynchronous |
| sync_ok | output | 1 | 1 when the data path is in sync |
| dsk_oor | output | 1 | 1 when the accepted deskew result is out of range |
| clk_avail | output | 1 | 1 while the ingress clock is detected |

## Verification
The sync and deskew flags are each a single register behind their pulse inputs, so each result is due one cycle after its pulse. The bench drives every pulse at a falling edge, holds it for one rising edge, and samples both flags at the next falling edge. Clock presence passes through the synchronizer and one more stage before it shows on clk_avail. The bench therefore waits well past that latency, and past the watchdog window, before it samples clk_avail. The forced loss of sync is sampled after the same wait.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int THR_W = 4;

    typedef logic [THR_W-1:0] run_t;

    typedef struct packed {
        logic in_sync;
        run_t good;
        run_t bad;
    } dip_st_t;

    typedef struct packed {
        logic oor;
        logic have;
        logic last;
    } dsk_st_t;

    function automatic run_t sat_inc(run_t v);
        return (v == '1) ? v : run_t'(v + 1'b1);
    endfunction

endpackage

// File: rtl/isq_clk_presence.sv
module isq_clk_presence #(
    parameter int WDOG_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ing_clk_div,
    output logic clk_avail
);
    localparam int CW = $clog2(WDOG_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CW-1:0]          cnt;
        logic                   avail;
    } cp_st_t;

    cp_st_t q, d;
    logic   toggle;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], ing_clk_div};
        d.prev = q.sync[SYNC_STAGES-1];
        toggle = q.sync[SYNC_STAGES-1] ^ q.prev;
        if (toggle) begin
            d.cnt   = CW'(WDOG_CYCLES);
            d.avail = 1'b1;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.avail = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign clk_avail = q.avail;

    // R8
    toggle_sets_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> clk_avail);

endmodule

// File: rtl/isq_dip_tracker.sv
module isq_dip_tracker
    import isq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clk_avail,
    input  logic dip_valid,
    input  logic dip_err,
    input  run_t insync_thr,
    input  run_t outsync_thr,
    output logic in_sync
);
    dip_st_t q, d;

    always_comb begin
        d = q;
        if (!enable || !clk_avail) begin
            d = '0;
        end else if (dip_valid) begin
            if (!dip_err) begin
                d.bad  = '0;
                d.good = sat_inc(q.good);
                if (!q.in_sync && (d.good >= insync_thr)) begin
                    d.in_sync = 1'b1;
                end
            end else begin
                d.good = '0;
                d.bad  = sat_inc(q.bad);
                if (q.in_sync && (d.bad >= outsync_thr)) begin
                    d.in_sync = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_sync = q.in_sync;

    // R3
    rise_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(dip_valid && !dip_err));

    // R5
    fall_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sync) |-> $past(!enable || !clk_avail || (dip_valid && dip_err)));

    // R9
    clk_loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_avail |=> !in_sync);

endmodule

// File: rtl/isq_deskew_qual.sv
module isq_deskew_qual
    import isq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic confirm,
    input  logic dsk_valid,
    input  logic dsk_in_range,
    output logic dsk_oor
);
    dsk_st_t q, d;

    always_comb begin
        d = q;
        if (!enable) begin
            d = '0;
        end else if (dsk_valid) begin
            if (!confirm || (q.have && (q.last == dsk_in_range))) begin
                d.oor = !dsk_in_range;
            end
            d.last = dsk_in_range;
            d.have = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dsk_oor = q.oor;

    // R6
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !confirm && dsk_valid) |=> (dsk_oor == !$past(dsk_in_range)));

    // R7
    hold_without_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && confirm && !dsk_valid) |=> $stable(dsk_oor));

    // R2
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !dsk_oor);

endmodule

// File: rtl/ingress_sync_qualifier.sv
module ingress_sync_qualifier
    import isq_pkg::*;
#(
    parameter int WDOG_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             dsk_confirm,
    input  logic [THR_W-1:0] insync_thr,
    input  logic [THR_W-1:0] outsync_thr,
    input  logic             dip_valid,
    input  logic             dip_err,
    input  logic             dsk_valid,
    input  logic             dsk_in_range,
    input  logic             ing_clk_div,
    output logic             sync_ok,
    output logic             dsk_oor,
    output logic             clk_avail
);
    logic avail_w;

    isq_clk_presence #(
        .WDOG_CYCLES(WDOG_CYCLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_clk_presence (
        .clk        (clk),
        .rst_n      (rst_n),
        .ing_clk_div(ing_clk_div),
        .clk_avail  (avail_w)
    );

    isq_dip_tracker u_dip_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .clk_avail  (avail_w),
        .dip_valid  (dip_valid),
        .dip_err    (dip_err),
        .insync_thr (insync_thr),
        .outsync_thr(outsync_thr),
        .in_sync    (sync_ok)
    );

    isq_deskew_qual u_deskew_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .confirm     (dsk_confirm),
        .dsk_valid   (dsk_valid),
        .dsk_in_range(dsk_in_range),
        .dsk_oor     (dsk_oor)
    );

    assign clk_avail = avail_w;

    // R2
    disabled_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sync_ok);

endmodule

// File: tb/ingress_sync_qualifier_bench.sv
module ingress_sync_qualifier_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       dsk_confirm = 1'b0;
    logic [3:0] insync_thr = 4'd8;
    logic [3:0] outsync_thr = 4'd8;
    logic       dip_valid = 1'b0;
    logic       dip_err = 1'b0;
    logic       dsk_valid = 1'b0;
    logic       dsk_in_range = 1'b0;
    logic       ing_clk_div = 1'b0;
    logic       sync_ok, dsk_oor, clk_avail;
    logic       tog_en = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    ingress_sync_qualifier u_ingress_sync_qualifier (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dsk_confirm(dsk_confirm),
        .insync_thr(insync_thr), .outsync_thr(outsync_thr),
        .dip_valid(dip_valid), .dip_err(dip_err),
        .dsk_valid(dsk_valid), .dsk_in_range(dsk_in_range),
        .ing_clk_div(ing_clk_div),
        .sync_ok(sync_ok), .dsk_oor(dsk_oor), .clk_avail(clk_avail)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            if (tog_en) ing_clk_div = ~ing_clk_div;
        end
    end

    // vector: {kind[1:0] (0 idle, 1 parity, 2 deskew), value, exp_sync, exp_oor}
    // value is dip_err for parity, dsk_in_range for deskew; thresholds 3 in, 2 out
    localparam int NV = 14;
    localparam logic [4:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b0, 1'b0},   // R3 good 1
        {2'd1, 1'b0, 1'b0, 1'b0},   // good 2
        {2'd1, 1'b1, 1'b0, 1'b0},   // R4 error restarts run
        {2'd1, 1'b0, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0},   // R3 idle keeps run
        {2'd1, 1'b0, 1'b1, 1'b0},   // R3 third good: in sync
        {2'd1, 1'b1, 1'b1, 1'b0},   // R5 one error
        {2'd1, 1'b0, 1'b1, 1'b0},   // R5 good clears error run
        {2'd1, 1'b1, 1'b1, 1'b0},
        {2'd1, 1'b1, 1'b0, 1'b0},   // R5 second error: out of sync
        {2'd2, 1'b0, 1'b0, 1'b1},   // R6
        {2'd2, 1'b1, 1'b0, 1'b0},   // R6
        {2'd2, 1'b0, 1'b0, 1'b1}    // R6
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic dip(input logic err);
        @(negedge clk);
        dip_valid = 1'b1; dip_err = err;
        @(negedge clk);
        dip_valid = 1'b0; dip_err = 1'b0;
    endtask

    task automatic dsk(input logic r);
        @(negedge clk);
        dsk_valid = 1'b1; dsk_in_range = r;
        @(negedge clk);
        dsk_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "sync_ok", sync_ok, 1'b0);
        check("R1", "dsk_oor", dsk_oor, 1'b0);
        check("R1", "clk_avail", clk_avail, 1'b0);

        tog_en = 1'b1;
        repeat (12) @(negedge clk);
        check("R8", "clk_avail present", clk_avail, 1'b1);
        // R2 pulses while disabled are ignored
        dip(1'b0); dsk(1'b0);
        check("R2", "sync_ok disabled", sync_ok, 1'b0);
        check("R2", "dsk_oor disabled", dsk_oor, 1'b0);

        insync_thr = 4'd3; outsync_thr = 4'd2;
        @(negedge clk); enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            case (VEC[i][4:3])
                2'd1: begin dip_valid = 1'b1; dip_err = VEC[i][2]; end
                2'd2: begin dsk_valid = 1'b1; dsk_in_range = VEC[i][2]; end
                default: ;
            endcase
            @(negedge clk);
            dip_valid = 1'b0; dip_err = 1'b0; dsk_valid = 1'b0;
            check("R3/R4/R5", $sformatf("vec %0d sync_ok", i), sync_ok, VEC[i][1]);
            check("R6", $sformatf("vec %0d dsk_oor", i), dsk_oor, VEC[i][0]);
        end

        // R7 confirm mode; previous result was out of range, oor=1
        dsk_confirm = 1'b1;
        dsk(1'b1); check("R7", "first differing", dsk_oor, 1'b1);
        dsk(1'b1); check("R7", "second matching", dsk_oor, 1'b0);
        dsk(1'b0); check("R7", "lone bad", dsk_oor, 1'b0);
        dsk(1'b1); check("R7", "differs again", dsk_oor, 1'b0);
        dsk(1'b0); dsk(1'b0); check("R7", "two bad", dsk_oor, 1'b1);
        dsk_confirm = 1'b0;

        // R9 clock loss clears run and sync
        dip(1'b0); dip(1'b0);
        tog_en = 1'b0;
        repeat (30) @(negedge clk);
        check("R8", "clk_avail lost", clk_avail, 1'b0);
        check("R9", "sync_ok clock lost", sync_ok, 1'b0);
        tog_en = 1'b1;
        repeat (12) @(negedge clk);
        check("R8", "clk_avail back", clk_avail, 1'b1);
        dip(1'b0);
        check("R9", "run cleared", sync_ok, 1'b0);
        dip(1'b0); dip(1'b0);
        check("R9", "resync", sync_ok, 1'b1);

        // R2 enable off
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        check("R2", "sync_ok after disable", sync_ok, 1'b0);
        check("R2", "dsk_oor after disable", dsk_oor, 1'b0);
        dip(1'b0); dip(1'b0);
        enable = 1'b1;
        dip(1'b0);
        check("R2", "run cleared on disable", sync_ok, 1'b0);

        // R3 threshold 0 acts as 1
        @(negedge clk); enable = 1'b0;
        insync_thr = 4'd0;
        @(negedge clk); enable = 1'b1;
        dip(1'b0);
        check("R3", "threshold zero", sync_ok, 1'b1);

        finish_run();
    end
endmodule